// File: doc/BRIEF.md
# Platform Power-Up Sequencer

This block takes a host chipset from an unpowered cold state to fully running without any software involvement. After reset it waits for the always-on 5 V supply and lets it settle. It then releases the deep-well power-ok and the resume-well reset, and lets the suspend clock settle. It dwells in the off state for one second and pulses a simulated power button. Next it waits for the chipset to release its four active-low sleep lines. It then switches on the system and memory rails, then the core rails, and finally asserts system power-ok.

Every wait is on a group of inputs, and all bits of the group must read high. A wait that lasts longer than the timeout is abandoned: the block emits a one-cycle timeout pulse together with a mask of the bits that were still low, and the sequence carries on. Every fixed delay counts whole milliseconds. A single shared down-counter provides them, with a prescaler of `CLK_PER_MS` clocks per millisecond. All status inputs pass through two-flop synchronizers. Two handshakes are wired straight through, independent of the sequence: the backlight request and the suspend-warning acknowledge.

Top module: `pwrseq_top`

## Requirements
- R1: While reset is held, all rail enables, `deep_well_ok_o`, `sys_pwr_ok_o`, `resume_rst_n_o` and `timeout_o` are low, `pwr_btn_n_o` and `ddr_shunt_o` are high, and `state_o` is 0.
- R2: `state_o` reports 0 = cold, 1 = off, 2 = on, 3 = cold-to-off, 4 = off-to-on. The cold state leaves for state 3 on the first clock after reset is released.
- R3: The input vector is {`sleep_n_i`[3:0], `pgood_i`[7:0]}. A wait ends when every bit of its group is high. After `TMO_MS` milliseconds (`TMO_MS*CLK_PER_MS+1` cycles from entry) it ends anyway. In that case `timeout_o` is high for one cycle, `miss_mask_o` holds the group bits that were low, and the next step proceeds.
- R4: In state 3 the block waits on bit 0 (5 V always-on good). `deep_well_ok_o` and `resume_rst_n_o` rise together `AON_SETTLE_MS*CLK_PER_MS+4` cycles after that input rises. State 1 follows `SUS_SETTLE_MS*CLK_PER_MS+1` cycles later.
- R5: State 1 lasts `S5_HOLD_MS*CLK_PER_MS+1` cycles. The block then enters state 4 and drives `pwr_btn_n_o` low in the same cycle.
- R6: `pwr_btn_n_o` stays low for exactly `BTN_MS*CLK_PER_MS+1` cycles. The block then waits on group 0xF00 (all sleep lines high).
- R7: Three cycles after the last sleep line rises, `rail_vs_en_o` and `ddr_en_o` go high and `ddr_shunt_o` goes low, all in the same cycle. The block then waits on non-core group 0x03E.
- R8: Three cycles after the non-core group is good, `core_en_o` rises. The block then waits on group 0x0FE (bits 6 = CPU core, 7 = graphics core). `sys_pwr_ok_o` rises and `state_o` becomes 2 exactly `PWROK_MS*CLK_PER_MS+4` cycles after that group is good.
- R9: `bl_en_o` equals `bl_req_i` combinationally at all times, including during reset.
- R10: `susp_ack_n_o` equals `susp_warn_n_i` combinationally at all times, including during reset.
- R11: Once in state 2, state and all sequenced outputs hold until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pgood_i | input | 8 | Rail good: 0 5V always-on, 1 DDR, 2 PCH 1.5V, 3 1.8V, 4 VCCP, 5 VCCSA, 6 CPU core, 7 graphics core |
| sleep_n_i | input | 4 | Active-low sleep lines: 0 S3, 1 S4, 2 S5, 3 A |
| bl_req_i | input | 1 | Backlight request from chipset |
| susp_warn_n_i | input | 1 | Suspend warning, active low |
| rail_vs_en_o | output | 1 | System rail enable |
| ddr_en_o | output | 1 | Memory rail enable |
| ddr_shunt_o | output | 1 | Memory rail shunt, high in reset |
| core_en_o | output | 1 | CPU and graphics core enable |
| deep_well_ok_o | output | 1 | Deep-well power-ok to chipset |
| resume_rst_n_o | output | 1 | Resume-well reset, active low |
| pwr_btn_n_o | output | 1 | Simulated power button, active low |
| sys_pwr_ok_o | output | 1 | System power-ok |
| bl_en_o | output | 1 | Backlight enable |
| susp_ack_n_o | output | 1 | Suspend acknowledge, active low |
| state_o | output | 3 | Sequence state code |
| timeout_o | output | 1 | One-cycle pulse per expired wait |
| miss_mask_o | output | 12 | Group bits still low at the last timeout |

## Verification
A wrong phase shows at the ports as an output edge that comes early, late or in the wrong order. Nearly every step has an exact cycle count from an observable input or output edge, so a fault in the counter or the phase logic moves a measured edge by at least one cycle within a few milliseconds of simulated time. A wrong wait group shows up in two ways. It can cause an unexpected timeout pulse with a wrong missing mask. Or it can cause an enable edge that no longer lands three cycles after the last input rises.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int NPG  = 8;
    localparam int NSLP = 4;
    localparam int NIN  = NPG + NSLP;

    // Wait groups over {sleep_n[3:0], pgood[7:0]}
    localparam logic [NIN-1:0] GRP_AON  = 12'h001;
    localparam logic [NIN-1:0] GRP_NC   = 12'h03E;
    localparam logic [NIN-1:0] GRP_CORE = 12'h0C0;
    localparam logic [NIN-1:0] GRP_SLP  = 12'hF00;

    typedef enum logic [2:0] {
        ST_COLD    = 3'd0,
        ST_OFF     = 3'd1,
        ST_ON      = 3'd2,
        ST_COLD_UP = 3'd3,
        ST_OFF_UP  = 3'd4
    } pstate_t;

    typedef enum logic [3:0] {
        PH_COLD, PH_WAIT_AON, PH_DLY_AON, PH_DLY_SUS, PH_OFF, PH_BTN,
        PH_WAIT_SLP, PH_WAIT_NC, PH_WAIT_ALL, PH_DLY_OK, PH_ON
    } phase_t;

    typedef struct packed {
        logic vs_en;
        logic ddr_en;
        logic ddr_shunt;
        logic core_en;
        logic dw_ok;
        logic rsm_rst_n;
        logic btn_n;
        logic sys_ok;
    } rail_t;

    localparam rail_t RAIL_RST = '{vs_en: 1'b0, ddr_en: 1'b0, ddr_shunt: 1'b1,
                                   core_en: 1'b0, dw_ok: 1'b0, rsm_rst_n: 1'b0,
                                   btn_n: 1'b1, sys_ok: 1'b0};

    typedef struct packed {
        phase_t         ph;
        rail_t          rail;
        logic           tmo;
        logic [NIN-1:0] miss;
    } seq_regs_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pstate_t phase_state(input phase_t p);
        case (p)
            PH_COLD:                                   return ST_COLD;
            PH_WAIT_AON, PH_DLY_AON, PH_DLY_SUS:       return ST_COLD_UP;
            PH_OFF:                                    return ST_OFF;
            PH_ON:                                     return ST_ON;
            default:                                   return ST_OFF_UP;
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] ff_d, ff_q;
        always_comb ff_d = {ff_q[0], d_i[i]};
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff_q <= '0;
            else         ff_q <= ff_d;
        end
        assign q_o[i] = ff_q[1];
    end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CLK_PER_MS = 1000,
    parameter int MS_W       = 10
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic [MS_W-1:0] load_ms_i,
    output logic            done_o
);
    localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLK_PER_MS - 1);

    typedef struct packed {
        logic [MS_W-1:0]  ms;
        logic [PRE_W-1:0] pre;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.ms  = load_ms_i;
            d.pre = PRE_TOP;
        end else if (q.ms != '0) begin
            if (q.pre == '0) begin
                d.ms  = q.ms - MS_W'(1);
                d.pre = PRE_TOP;
            end else begin
                d.pre = q.pre - PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign done_o = (q.ms == '0);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm import pwrseq_pkg::*; #(
    parameter int MS_W          = 10,
    parameter int TMO_MS        = 1000,
    parameter int AON_SETTLE_MS = 10,
    parameter int SUS_SETTLE_MS = 5,
    parameter int S5_HOLD_MS    = 1000,
    parameter int BTN_MS        = 16,
    parameter int PWROK_MS      = 99
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NIN-1:0]  in_i,
    input  logic            tmr_done_i,
    output logic            tmr_load_o,
    output logic [MS_W-1:0] tmr_ms_o,
    output rail_t           rail_o,
    output logic [2:0]      state_o,
    output logic            tmo_o,
    output logic [NIN-1:0]  miss_o
);
    seq_regs_t d, q;
    logic [NIN-1:0] want;
    logic hit, advance;

    always_comb begin
        case (q.ph)
            PH_WAIT_AON: want = GRP_AON;
            PH_WAIT_SLP: want = GRP_SLP;
            PH_WAIT_NC:  want = GRP_NC;
            PH_WAIT_ALL: want = GRP_NC | GRP_CORE;
            default:     want = '0;
        endcase
        hit     = ((in_i & want) == want);
        advance = hit || tmr_done_i;

        d          = q;
        d.tmo      = 1'b0;
        tmr_load_o = 1'b0;
        tmr_ms_o   = '0;

        if (want != '0 && advance && !hit) begin
            d.tmo  = 1'b1;
            d.miss = want & ~in_i;
        end

        case (q.ph)
            PH_COLD: begin
                d.ph = PH_WAIT_AON; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(TMO_MS);
            end
            PH_WAIT_AON: if (advance) begin
                d.ph = PH_DLY_AON; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(AON_SETTLE_MS);
            end
            PH_DLY_AON: if (tmr_done_i) begin
                d.rail.dw_ok = 1'b1; d.rail.rsm_rst_n = 1'b1;
                d.ph = PH_DLY_SUS; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(SUS_SETTLE_MS);
            end
            PH_DLY_SUS: if (tmr_done_i) begin
                d.ph = PH_OFF; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(S5_HOLD_MS);
            end
            PH_OFF: if (tmr_done_i) begin
                d.rail.btn_n = 1'b0;
                d.ph = PH_BTN; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(BTN_MS);
            end
            PH_BTN: if (tmr_done_i) begin
                d.rail.btn_n = 1'b1;
                d.ph = PH_WAIT_SLP; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(TMO_MS);
            end
            PH_WAIT_SLP: if (advance) begin
                d.rail.vs_en = 1'b1; d.rail.ddr_shunt = 1'b0; d.rail.ddr_en = 1'b1;
                d.ph = PH_WAIT_NC; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(TMO_MS);
            end
            PH_WAIT_NC: if (advance) begin
                d.rail.core_en = 1'b1;
                d.ph = PH_WAIT_ALL; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(TMO_MS);
            end
            PH_WAIT_ALL: if (advance) begin
                d.ph = PH_DLY_OK; tmr_load_o = 1'b1; tmr_ms_o = MS_W'(PWROK_MS);
            end
            PH_DLY_OK: if (tmr_done_i) begin
                d.rail.sys_ok = 1'b1;
                d.ph = PH_ON;
            end
            PH_ON: d.ph = PH_ON;
            default: d.ph = PH_COLD;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{ph: PH_COLD, rail: RAIL_RST, tmo: 1'b0, miss: '0};
        else         q <= d;
    end

    assign rail_o  = q.rail;
    assign state_o = phase_state(q.ph);
    assign tmo_o   = q.tmo;
    assign miss_o  = q.miss;
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top import pwrseq_pkg::*; #(
    parameter int CLK_PER_MS    = 1000,
    parameter int TMO_MS        = 1000,
    parameter int AON_SETTLE_MS = 10,
    parameter int SUS_SETTLE_MS = 5,
    parameter int S5_HOLD_MS    = 1000,
    parameter int BTN_MS        = 16,
    parameter int PWROK_MS      = 99
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [7:0]      pgood_i,
    input  logic [3:0]      sleep_n_i,
    input  logic            bl_req_i,
    input  logic            susp_warn_n_i,
    output logic            rail_vs_en_o,
    output logic            ddr_en_o,
    output logic            ddr_shunt_o,
    output logic            core_en_o,
    output logic            deep_well_ok_o,
    output logic            resume_rst_n_o,
    output logic            pwr_btn_n_o,
    output logic            sys_pwr_ok_o,
    output logic            bl_en_o,
    output logic            susp_ack_n_o,
    output logic [2:0]      state_o,
    output logic            timeout_o,
    output logic [11:0]     miss_mask_o
);
    localparam int MAX_MS = max_int(max_int(max_int(TMO_MS, S5_HOLD_MS),
                                            max_int(AON_SETTLE_MS, SUS_SETTLE_MS)),
                                    max_int(BTN_MS, PWROK_MS));
    localparam int MS_W = $clog2(MAX_MS + 1);

    logic [NIN-1:0]  in_sync;
    logic            tmr_load, tmr_done;
    logic [MS_W-1:0] tmr_ms;
    rail_t           rail;

    pwrseq_sync #(.W(NIN)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .d_i({sleep_n_i, pgood_i}), .q_o(in_sync)
    );

    pwrseq_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) u_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .load_i(tmr_load), .load_ms_i(tmr_ms), .done_o(tmr_done)
    );

    pwrseq_fsm #(
        .MS_W(MS_W), .TMO_MS(TMO_MS), .AON_SETTLE_MS(AON_SETTLE_MS),
        .SUS_SETTLE_MS(SUS_SETTLE_MS), .S5_HOLD_MS(S5_HOLD_MS),
        .BTN_MS(BTN_MS), .PWROK_MS(PWROK_MS)
    ) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .in_i(in_sync), .tmr_done_i(tmr_done),
        .tmr_load_o(tmr_load), .tmr_ms_o(tmr_ms), .rail_o(rail),
        .state_o(state_o), .tmo_o(timeout_o), .miss_o(miss_mask_o)
    );

    assign rail_vs_en_o   = rail.vs_en;
    assign ddr_en_o       = rail.ddr_en;
    assign ddr_shunt_o    = rail.ddr_shunt;
    assign core_en_o      = rail.core_en;
    assign deep_well_ok_o = rail.dw_ok;
    assign resume_rst_n_o = rail.rsm_rst_n;
    assign pwr_btn_n_o    = rail.btn_n;
    assign sys_pwr_ok_o   = rail.sys_ok;

    assign bl_en_o      = bl_req_i;
    assign susp_ack_n_o = susp_warn_n_i;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        rail_vs_en_o,
    input logic        ddr_en_o,
    input logic        ddr_shunt_o,
    input logic        core_en_o,
    input logic        deep_well_ok_o,
    input logic        resume_rst_n_o,
    input logic        pwr_btn_n_o,
    input logic        sys_pwr_ok_o,
    input logic [2:0]  state_o,
    input logic        timeout_o,
    input logic [11:0] miss_mask_o
);
    AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni) state_o <= 3'd4); // R2
    AST_COLD_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni) state_o == 3'd0 |=> state_o == 3'd3); // R2
    AST_TMO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) timeout_o |=> !timeout_o); // R3
    AST_TMO_HAS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni) timeout_o |-> miss_mask_o != 12'h000); // R3
    AST_RSM_WITH_DWOK: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(deep_well_ok_o) |-> resume_rst_n_o && state_o == 3'd3); // R4
    AST_BTN_IN_OFF_UP: assert property (@(posedge clk_i) disable iff (!rst_ni) !pwr_btn_n_o |-> state_o == 3'd4 && !rail_vs_en_o); // R6
    AST_DDR_NO_SHUNT: assert property (@(posedge clk_i) disable iff (!rst_ni) ddr_en_o |-> !ddr_shunt_o && rail_vs_en_o); // R7
    AST_CORE_AFTER_DDR: assert property (@(posedge clk_i) disable iff (!rst_ni) core_en_o |-> ddr_en_o && deep_well_ok_o); // R8
    AST_PWROK_IN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni) sys_pwr_ok_o |-> state_o == 3'd2 && core_en_o); // R8
    AST_ON_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni) state_o == 3'd2 |=> state_o == 3'd2 && $stable({rail_vs_en_o, ddr_en_o, ddr_shunt_o, core_en_o, sys_pwr_ok_o})); // R11
endmodule

bind pwrseq_top pwrseq_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rail_vs_en_o(rail_vs_en_o), .ddr_en_o(ddr_en_o), .ddr_shunt_o(ddr_shunt_o),
    .core_en_o(core_en_o), .deep_well_ok_o(deep_well_ok_o),
    .resume_rst_n_o(resume_rst_n_o), .pwr_btn_n_o(pwr_btn_n_o),
    .sys_pwr_ok_o(sys_pwr_ok_o), .state_o(state_o), .timeout_o(timeout_o),
    .miss_mask_o(miss_mask_o)
);

// File: tb/sim_pwrseq_top.sv
`timescale 1ns/1ps
module sim_pwrseq_top;
    localparam int CPM = 2;
    localparam int TMO = 1000, AON = 10, SUS = 5, HOLD = 1000, BTN = 16, POK = 99;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] pg = '0;
    logic [3:0] slp_n = '0;
    logic bl_req = 1'b0, warn_n = 1'b1;
    logic vs_en, ddr_en, shunt, core_en, dw_ok, rsm_n, btn_n, sys_ok, bl_en, ack_n, tmo;
    logic [2:0] st;
    logic [11:0] miss;

    pwrseq_top #(.CLK_PER_MS(CPM)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .pgood_i(pg), .sleep_n_i(slp_n),
        .bl_req_i(bl_req), .susp_warn_n_i(warn_n),
        .rail_vs_en_o(vs_en), .ddr_en_o(ddr_en), .ddr_shunt_o(shunt), .core_en_o(core_en),
        .deep_well_ok_o(dw_ok), .resume_rst_n_o(rsm_n), .pwr_btn_n_o(btn_n),
        .sys_pwr_ok_o(sys_ok), .bl_en_o(bl_en), .susp_ack_n_o(ack_n),
        .state_o(st), .timeout_o(tmo), .miss_mask_o(miss)
    );

    int checks = 0, fails = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ms_cyc(input int ms);
        return ms * CPM + 1;
    endfunction
    function automatic int exp_dwok(input bit m_aon, input int t_aon);
        return m_aon ? 1 + ms_cyc(TMO) + ms_cyc(AON) : t_aon + 3 + ms_cyc(AON);
    endfunction
    function automatic int exp_pwrok(input bit m_gfx, input int t_vc, input int t_core);
        return m_gfx ? t_vc + ms_cyc(TMO) + ms_cyc(POK) : t_core + 3 + ms_cyc(POK);
    endfunction

    task automatic drive_pass();
        bl_req = 1'($urandom % 2);
        warn_n = 1'($urandom % 2);
        #1;
        chk("R9 backlight", int'(bl_en), int'(bl_req));
        chk("R10 suspend ack", int'(ack_n), int'(warn_n));
    endtask

    task automatic scenario(input bit m_aon, input bit m_slpa, input bit m_gfx);
        int c = 0;
        int t_aon = -1, t_dw = -1, t_rsm = -1, t_s5 = -1, t_lo = -1, t_hi = -1, t_slp = -1;
        int t_en = -1, t_nc = -1, t_vc = -1, t_core = -1, t_pw = -1, t_to = -1;
        int n_to = 0, mask = 0, st_dw = -1, st_lo = -1, st_pw = -1, en_ok = 0;
        int d_aon = 5 + int'($urandom % 30);
        int d_slp = int'($urandom % 20);
        int d_nc  = int'($urandom % 20);
        int d_core = int'($urandom % 20);
        logic [7:0] hold_rail;

        rst_n = 1'b0; pg = '0; slp_n = '0;
        repeat (3) begin
            @(negedge clk);
            drive_pass();
        end
        // R1: {vs,ddr,shunt,core,dwok,rsm,btn,sysok,tmo,state}
        chk("R1 reset outputs", int'({vs_en, ddr_en, shunt, core_en, dw_ok, rsm_n, btn_n, sys_ok, tmo, st}),
            int'({8'b0010_0010, 1'b0, 3'd0}));
        rst_n = 1'b1;

        while (t_pw < 0 && c < 9000) begin
            @(negedge clk);
            c++;
            if (c == 1) chk("R2 cold leaves at once", int'(st), 3);
            if (tmo) begin n_to++; mask = int'(miss); if (t_to < 0) t_to = c; end
            if (dw_ok && t_dw < 0) begin t_dw = c; st_dw = int'(st); end
            if (rsm_n && t_rsm < 0) t_rsm = c;
            if (st == 3'd1 && t_s5 < 0) t_s5 = c;
            if (!btn_n && t_lo < 0) begin t_lo = c; st_lo = int'(st); end
            if (t_lo >= 0 && btn_n && t_hi < 0) t_hi = c;
            if (vs_en && t_en < 0) begin t_en = c; en_ok = int'(ddr_en && !shunt); end
            if (core_en && t_vc < 0) t_vc = c;
            if (sys_ok && t_pw < 0) begin t_pw = c; st_pw = int'(st); end
            // board model
            if (!m_aon && c == d_aon) begin pg[0] = 1'b1; t_aon = c; end
            if (t_hi >= 0 && c == t_hi + d_slp) begin slp_n = m_slpa ? 4'h7 : 4'hF; t_slp = c; end
            if (t_en >= 0 && c == t_en + d_nc) begin pg[5:1] = '1; t_nc = c; end
            if (t_vc >= 0 && c == t_vc + d_core) begin pg[6] = 1'b1; pg[7] = !m_gfx; t_core = c; end
            drive_pass();
        end

        chk("R8 power-ok reached", int'(t_pw >= 0), 1);
        chk("R4 deep-well ok timing", t_dw, exp_dwok(m_aon, t_aon));
        chk("R4 resume reset with deep-well ok", t_rsm, t_dw);
        chk("R2 state during cold-to-off", st_dw, 3);
        chk("R4 off state entry", t_s5, t_dw + ms_cyc(SUS));
        chk("R5 button press after off dwell", t_lo, t_s5 + ms_cyc(HOLD));
        chk("R5 state during button", st_lo, 4);
        chk("R6 button width", t_hi - t_lo, ms_cyc(BTN));
        chk("R7 rail enable timing", t_en, m_slpa ? t_hi + ms_cyc(TMO) : t_slp + 3);
        chk("R7 ddr on and shunt off together", en_ok, 1);
        chk("R8 core enable timing", t_vc, t_nc + 3);
        chk("R8 power-ok timing", t_pw, exp_pwrok(m_gfx, t_vc, t_core));
        chk("R8 state on", st_pw, 2);
        chk("R3 timeout count", n_to, int'(m_aon) + int'(m_slpa) + int'(m_gfx));
        if (m_aon)  chk("R3 missing mask aon", mask, 'h001);
        if (m_slpa) chk("R3 missing mask sleep A", mask, 'h800);
        if (m_gfx)  chk("R3 missing mask gfx", mask, 'h080);

        hold_rail = {vs_en, ddr_en, shunt, core_en, dw_ok, rsm_n, btn_n, sys_ok};
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            pg = 8'($urandom);
            slp_n = 4'($urandom);
            drive_pass();
        end
        repeat (3) @(negedge clk);
        chk("R11 on state holds", int'(st), 2);
        chk("R11 outputs hold", int'({vs_en, ddr_en, shunt, core_en, dw_ok, rsm_n, btn_n, sys_ok}),
            int'(hold_rail));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        scenario(1'b0, 1'b0, 1'b0);
        scenario(1'b0, 1'b0, 1'b0);
        scenario(1'b1, 1'b0, 1'b0);
        scenario(1'b0, 1'b1, 1'b0);
        scenario(1'b0, 1'b0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule